// File: doc/BRIEF.md
# Ordered-Event Runtime Monitor

This block is a small synthesizable watcher for one temporal rule over three single-bit signals taken from a design under observation. A trigger event (`arm_i`) opens an obligation that takes effect from the next rising clock edge. While the obligation is open, the release event (`lead_i`) has to be seen strictly before the fault event (`fault_i`). If the fault event comes first, or arrives in the same cycle as the release event, the rule is broken.

The monitor samples all inputs on the rising edge of `clk`. It reports each breach as a one-cycle pulse and also keeps a latched breach flag. It shows whether an obligation is currently open, and it gives a level output that stays high for as long as no breach has occurred since reset. It can be placed beside a design in simulation, or compiled into an FPGA prototype as a permanent on-chip checker.

Top module: `order_watch`

## Requirements
- R1: A synchronous active-high reset `rst`, sampled on the rising edge, clears the open obligation, the breach pulse and the latched flag. After reset, `waiting_o`=0, `hit_o`=0, `latched_o`=0 and `clean_o`=1.
- R2: `arm_i` high at a rising edge makes `waiting_o` high after that edge, whatever the state was before.
- R3: While `waiting_o` is high, an edge that samples `lead_i`=1 and `fault_i`=0 closes the obligation with no pulse. After that edge, `waiting_o` equals the `arm_i` value sampled at the same edge.
- R4: While `waiting_o` is high, an edge that samples `fault_i`=1 produces `hit_o`=1 for the following cycle. This also applies when `lead_i` is 1 at the same edge.
- R5: `hit_o` is high only in the cycle after an edge at which `waiting_o` was high and `fault_i` was 1. Otherwise it is 0, so each breach gives exactly one cycle of pulse.
- R6: `latched_o` goes high together with the first `hit_o` pulse and stays high until reset. `clean_o` is always the inverse of `latched_o`.
- R7: While `waiting_o` is low, `lead_i` and `fault_i` have no effect. No pulse appears, and `waiting_o` follows only `arm_i`.
- R8: An `arm_i` that arrives while an obligation is open does not stack a second obligation. After that edge a single `lead_i`-only edge closes the obligation (with `arm_i` low).
- R9: While `waiting_o` is high, an edge that samples both `lead_i` and `fault_i` low keeps `waiting_o` high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge sampling clock |
| rst | input | 1 | Synchronous active-high reset |
| arm_i | input | 1 | Trigger event that opens an obligation from the next edge |
| lead_i | input | 1 | Release event that must come before the fault |
| fault_i | input | 1 | Fault event that must not come first |
| waiting_o | output | 1 | An obligation is open |
| hit_o | output | 1 | One-cycle pulse for each breach |
| latched_o | output | 1 | A breach has occurred since reset |
| clean_o | output | 1 | No breach has occurred since reset |

## Verification
The assertions assume that the three observed signals are already synchronous to `clk` and hold a defined 0 or 1 at every rising edge. They also assume that `rst` is held for at least one edge before checking is expected to start.

The bench follows these assumptions. It changes inputs only one time unit after a rising edge and starts with a reset. It applies random three-bit patterns, whose rates are biased so that open obligations last several cycles. It inserts occasional resets so that the latched flag does not stay set for the rest of the run.

// File: rtl/order_watch.sv
module order_watch (
  input  logic clk,
  input  logic rst,
  input  logic arm_i,
  input  logic lead_i,
  input  logic fault_i,
  output logic waiting_o,
  output logic hit_o,
  output logic latched_o,
  output logic clean_o
);

  logic breach;
  logic release_ok;

  assign breach     = waiting_o & fault_i;
  assign release_ok = waiting_o & lead_i & ~fault_i;
  assign clean_o    = ~latched_o;

  always_ff @(posedge clk) begin
    if (rst) begin
      waiting_o <= 1'b0;
      hit_o     <= 1'b0;
      latched_o <= 1'b0;
    end else begin
      hit_o     <= breach;
      if (breach) latched_o <= 1'b1;
      waiting_o <= arm_i | (waiting_o & ~breach & ~release_ok);
    end
  end

  assert_arm_opens_R2: assert property (@(posedge clk) disable iff (rst)
    arm_i |=> waiting_o);

  assert_release_closes_R3: assert property (@(posedge clk) disable iff (rst)
    (waiting_o && lead_i && !fault_i && !arm_i) |=> (!waiting_o && !hit_o));

  assert_fault_pulses_R4: assert property (@(posedge clk) disable iff (rst)
    (waiting_o && fault_i) |=> hit_o);

  assert_no_stray_pulse_R5: assert property (@(posedge clk) disable iff (rst)
    !(waiting_o && fault_i) |=> !hit_o);

  assert_latch_holds_R6: assert property (@(posedge clk) disable iff (rst)
    latched_o |=> latched_o);

  assert_latch_with_pulse_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(latched_o) |-> hit_o);

  assert_idle_ignores_R7: assert property (@(posedge clk) disable iff (rst)
    (!waiting_o && !arm_i) |=> (!waiting_o && !hit_o));

  assert_quiet_keeps_R9: assert property (@(posedge clk) disable iff (rst)
    (waiting_o && !lead_i && !fault_i) |=> waiting_o);

endmodule

// File: tb/order_watch_bench.sv
module order_watch_bench;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst, arm_i, lead_i, fault_i;
  logic waiting_o, hit_o, latched_o, clean_o;

  int compared = 0;
  int mismatched = 0;
  logic [2:0] exp_s;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  order_watch u_order_watch (
    .clk(clk), .rst(rst), .arm_i(arm_i), .lead_i(lead_i), .fault_i(fault_i),
    .waiting_o(waiting_o), .hit_o(hit_o), .latched_o(latched_o), .clean_o(clean_o)
  );

  function automatic logic [2:0] model_next(logic [2:0] s, logic a, logic g, logic b);
    logic w, p, l;
    w = s[2]; l = s[0]; p = 1'b0;
    if (w) begin
      if (b) begin p = 1'b1; l = 1'b1; w = a; end
      else if (g) w = a;
      else w = 1'b1;
    end else w = a;
    return {w, p, l};
  endfunction

  task automatic cmp(string req, string name, logic act, logic exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s %s actual=%b expected=%b at %0t", req, name, act, exp, $time);
    end
  endtask

  task automatic check_all(string req);
    cmp(req, "waiting_o", waiting_o, exp_s[2]);
    cmp(req, "hit_o", hit_o, exp_s[1]);
    cmp(req, "latched_o", latched_o, exp_s[0]);
    cmp(req, "clean_o", clean_o, ~exp_s[0]);
  endtask

  task automatic step(string req, logic r, logic a, logic g, logic b);
    rst = r; arm_i = a; lead_i = g; fault_i = b;
    exp_s = r ? 3'b000 : model_next(exp_s, a, g, b);
    @(posedge clk); #1;
    check_all(req);
  endtask

  initial begin
    rst = 1'b1; arm_i = 1'b0; lead_i = 1'b0; fault_i = 1'b0; exp_s = 3'b000;
    @(posedge clk); #1;
    step("R1", 1, 1, 1, 1);
    check_all("R1");
    // R7: idle ignores lead/fault
    step("R7", 0, 0, 1, 1);
    step("R7", 0, 0, 0, 1);
    // R2 then R9 quiet then R3 release
    step("R2", 0, 1, 0, 0);
    step("R9", 0, 0, 0, 0);
    step("R9", 0, 0, 0, 0);
    step("R3", 0, 0, 1, 0);
    // R3 with re-arm in same edge
    step("R2", 0, 1, 0, 0);
    step("R3", 0, 1, 1, 0);
    step("R3", 0, 0, 1, 0);
    // R4: simultaneous lead+fault is a breach
    step("R2", 0, 1, 1, 1);
    step("R4", 0, 0, 1, 1);
    step("R5", 0, 0, 0, 0);
    step("R6", 0, 0, 0, 0);
    // R8: re-arm while open, one release closes
    step("R1", 1, 0, 0, 0);
    step("R2", 0, 1, 0, 0);
    step("R8", 0, 1, 0, 0);
    step("R8", 0, 1, 0, 0);
    step("R8", 0, 0, 1, 0);
    step("R8", 0, 0, 0, 1);
    // R4/R5 back-to-back breaches with re-arm
    step("R2", 0, 1, 0, 0);
    step("R4", 0, 1, 0, 1);
    step("R5", 0, 0, 0, 1);
    step("R6", 0, 0, 0, 0);
    // random phase
    void'($urandom(32'd1234));
    for (int i = 0; i < 4000; i++) begin
      logic r, a, g, b;
      r = ($urandom % 60) == 0;
      a = ($urandom % 5) == 0;
      g = ($urandom % 4) == 0;
      b = ($urandom % 6) == 0;
      step("R3/R4/R9", r, a, g, b);
    end
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        compared++; mismatched++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule